// File: doc/BRIEF.md
# Pipelined Block Read Master

This block fetches a run of consecutive words from a memory-mapped slave and parks them in an internal FIFO for a simple consumer. A controller gives a start byte address and a byte length, then pulses a start strobe for one cycle. The block drops its idle flag and issues read requests, one word per accepted request. Each address advances by the word size in bytes.

Several reads may be in flight at once. The slave accepts a request in any cycle where its stall input is low, and it returns data later, in order, each word marked by a valid strobe. Every returned word is pushed into the FIFO. The consumer sees a not-empty flag and the word at the head of the FIFO, and it pops that word with a one-cycle acknowledge.

Request issue is throttled. A new request is started only while the FIFO occupancy plus the number of outstanding requests is below the FIFO depth minus a fixed margin. As a result the FIFO cannot overflow, however long the slave latency is and however slowly the consumer drains it.

Top module: `pipe_rd_master`

## Requirements
- R1: After a synchronous reset, `ctl_done` is 1, `bus_read` is 0 and `usr_avail` is 0.
- R2: When `ctl_go` is high, `ctl_done` is 1 and `ctl_len` is nonzero, the start address and length are latched and `ctl_done` reads 0 from the next cycle. The transfer covers ceil(`ctl_len` / BE_W) words, where BE_W is the word size in bytes (2 by default).
- R3: The k-th accepted request (k from 0) carries address start + k*BE_W. A request counts as accepted when `bus_read` is 1 and `bus_waitreq` is 0. Exactly ceil(len/BE_W) requests are accepted, and `bus_read` stays 0 once the last one is accepted.
- R4: While `bus_read` is 1 and `bus_waitreq` is 1, `bus_read` stays 1 and `bus_addr` stays unchanged in the following cycle.
- R5: A request that is newly raised (not held over from a stalled cycle) appears only while FIFO occupancy plus outstanding requests is below FIFO_DEPTH-4 (28 by default). A consumer that never pops therefore leaves exactly 28 words buffered.
- R6: Each word returned with `bus_rvalid` enters the FIFO in return order. `usr_avail` is 1 exactly when the FIFO holds at least one word, and `usr_data` shows the oldest word.
- R7: A one-cycle `usr_ack` while the FIFO is nonempty removes exactly one word. An acknowledge while the FIFO is empty has no effect.
- R8: `ctl_done` returns to 1 in the same cycle that the final word of the transfer first appears in the FIFO.
- R9: A `ctl_go` pulse while `ctl_done` is 0 is ignored. The running transfer keeps its addresses and word count.
- R10: A `ctl_go` pulse with `ctl_len` equal to 0 leaves `ctl_done` at 1 and issues no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_go | input | 1 | One-cycle start strobe |
| ctl_addr | input | ADDR_W | Start byte address |
| ctl_len | input | LEN_W | Transfer length in bytes |
| ctl_done | output | 1 | High while idle |
| bus_addr | output | ADDR_W | Request byte address |
| bus_read | output | 1 | Read request strobe |
| bus_waitreq | input | 1 | Slave stall; request not accepted while high |
| bus_rdata | input | DATA_W | Returned read data |
| bus_rvalid | input | 1 | Returned data valid |
| usr_avail | output | 1 | FIFO holds at least one word |
| usr_data | output | DATA_W | Word at the FIFO head |
| usr_ack | input | 1 | Pop the head word |

## Verification
The first pattern is a fast slave with latency 1, no stalls and a consumer that always acknowledges. It checks plain address stepping, in-order delivery and the timing of the done flag, and the constant acknowledge also covers popping an empty FIFO. Random stalls with a latency that varies from 1 to 6 show whether the request is held steady under stall and whether several requests can be outstanding at once. A consumer that stops acknowledging for a long run isolates the throttle: the buffered level must settle at exactly the limit, with no further requests. Odd byte lengths, zero lengths and a restart strobe sent mid-transfer separate the rounding, the empty-transfer path and the busy-ignore path.

// File: rtl/prm_pkg.sv
package prm_pkg;
  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_RUN  = 1'b1
  } prm_phase_e;
endpackage

// File: rtl/prm_pending_cnt.sv
module prm_pending_cnt #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_d
);
  always_comb begin
    cnt_d = cnt_q;
    if (inc && !dec) cnt_d = cnt_q + CNT_W'(1);
    else if (dec && !inc) cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  // R3
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    dec |-> (cnt_q != '0));
endmodule

// File: rtl/prm_fifo.sv
module prm_fifo #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 32,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] head,
  output logic              not_empty,
  output logic [CNT_W-1:0]  used_q
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic              do_pop;

  assign do_pop    = rd_en && (used_q != '0);
  assign not_empty = (used_q != '0);
  assign head      = mem[rd_ptr];

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      used_q <= '0;
    end else begin
      if (wr_en)  wr_ptr <= bump(wr_ptr);
      if (do_pop) rd_ptr <= bump(rd_ptr);
      if (wr_en && !do_pop)      used_q <= used_q + CNT_W'(1);
      else if (do_pop && !wr_en) used_q <= used_q - CNT_W'(1);
    end
  end

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (used_q < CNT_W'(DEPTH)));

  // R7
  pop_one_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && used_q != '0 && !wr_en) |=> (used_q == $past(used_q) - CNT_W'(1)));
endmodule

// File: rtl/prm_issue.sv
module prm_issue
  import prm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int BYTES  = 2,
  parameter int CNT_W  = 6,
  parameter int LIMIT  = 28
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LEN_W-1:0]  len,
  input  logic              waitreq,
  input  logic [CNT_W-1:0]  fifo_used,
  input  logic [CNT_W-1:0]  pend_q,
  input  logic [CNT_W-1:0]  pend_d,
  output logic              rd_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic              done_q,
  output logic              accept
);
  localparam int SUM_W = CNT_W + 1;

  prm_phase_e        phase;
  logic [LEN_W-1:0]  rem_q, rem_after;
  logic [SUM_W-1:0]  load;
  logic              room, go_take;

  assign phase   = done_q ? PH_IDLE : PH_RUN;
  assign accept  = rd_q && !waitreq;
  assign go_take = go && (phase == PH_IDLE) && (len != '0);
  assign load    = SUM_W'(fifo_used) + SUM_W'(pend_q) + SUM_W'(accept);
  assign room    = load < SUM_W'(LIMIT);

  always_comb begin
    rem_after = rem_q;
    if (accept) rem_after = (rem_q > LEN_W'(BYTES)) ? rem_q - LEN_W'(BYTES) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q   <= 1'b0;
      addr_q <= '0;
      rem_q  <= '0;
      done_q <= 1'b1;
    end else if (go_take) begin
      addr_q <= start_addr;
      rem_q  <= len;
      done_q <= 1'b0;
      rd_q   <= room;
    end else if (phase == PH_RUN) begin
      rem_q <= rem_after;
      if (accept) addr_q <= addr_q + ADDR_W'(BYTES);
      if (!(rd_q && waitreq)) rd_q <= (rem_after != '0) && room;
      done_q <= (rem_after == '0) && (pend_d == '0);
    end
  end

  // R2
  done_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (go && done_q && len != '0) |=> !done_q);

  // R4
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_q && waitreq) |=> (rd_q && $stable(addr_q)));

  // R5
  throttle_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_q && !$past(rd_q && waitreq)) |-> ((SUM_W'(fifo_used) + SUM_W'(pend_q)) < SUM_W'(LIMIT)));

  // R9
  busy_go_chk: assert property (@(posedge clk) disable iff (rst)
    (go && !done_q && !accept) |=> $stable(addr_q));

  // R10
  zero_len_chk: assert property (@(posedge clk) disable iff (rst)
    (go && done_q && len == '0) |=> (done_q && !rd_q));
endmodule

// File: rtl/pipe_rd_master.sv
module pipe_rd_master #(
  parameter int DATA_W     = 16,
  parameter int BE_W       = 2,
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int FIFO_DEPTH = 32,
  parameter int MARGIN     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_go,
  input  logic [ADDR_W-1:0] ctl_addr,
  input  logic [LEN_W-1:0]  ctl_len,
  output logic              ctl_done,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_read,
  input  logic              bus_waitreq,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_rvalid,
  output logic              usr_avail,
  output logic [DATA_W-1:0] usr_data,
  input  logic              usr_ack
);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
  localparam int LIMIT = FIFO_DEPTH - MARGIN;

  logic [CNT_W-1:0] fifo_used, pend_q, pend_d;
  logic             accept;

  prm_issue #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .BYTES(BE_W), .CNT_W(CNT_W), .LIMIT(LIMIT)
  ) u_issue (
    .clk(clk), .rst(rst), .go(ctl_go), .start_addr(ctl_addr), .len(ctl_len),
    .waitreq(bus_waitreq), .fifo_used(fifo_used), .pend_q(pend_q), .pend_d(pend_d),
    .rd_q(bus_read), .addr_q(bus_addr), .done_q(ctl_done), .accept(accept)
  );

  prm_pending_cnt #(.CNT_W(CNT_W)) u_pend (
    .clk(clk), .rst(rst), .inc(accept), .dec(bus_rvalid),
    .cnt_q(pend_q), .cnt_d(pend_d)
  );

  prm_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_fifo (
    .clk(clk), .rst(rst), .wr_en(bus_rvalid), .wr_data(bus_rdata),
    .rd_en(usr_ack), .head(usr_data), .not_empty(usr_avail), .used_q(fifo_used)
  );

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    $past(rst) |-> (ctl_done && !bus_read && !usr_avail));
endmodule

// File: tb/pipe_rd_master_tb.sv
module pipe_rd_master_tb;
  localparam int DW = 16, BE = 2, AW = 32, LW = 16, DEPTH = 32, LIMIT = DEPTH - 4;
  localparam int WD = 150000;

  logic clk = 1'b0, rst = 1'b1;
  logic ctl_go = 1'b0, bus_waitreq = 1'b0, bus_rvalid = 1'b0, usr_ack = 1'b0;
  logic [AW-1:0] ctl_addr = '0, bus_addr;
  logic [LW-1:0] ctl_len = '0;
  logic [DW-1:0] bus_rdata = '0, usr_data;
  logic ctl_done, bus_read, usr_avail;

  always #2.5 clk = ~clk;

  pipe_rd_master u_dut (
    .clk(clk), .rst(rst), .ctl_go(ctl_go), .ctl_addr(ctl_addr), .ctl_len(ctl_len),
    .ctl_done(ctl_done), .bus_addr(bus_addr), .bus_read(bus_read),
    .bus_waitreq(bus_waitreq), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .usr_avail(usr_avail), .usr_data(usr_data), .usr_ack(usr_ack)
  );

  int checks = 0, fails = 0, cyc = 0;
  logic [DW-1:0] mq[$];
  logic [DW-1:0] resp_d[$];
  int            resp_t[$];
  int  last_due = 0, issued = 0, total = 0, ret = 0, infl = 0;
  bit  done_m = 1'b1, prev_hold = 1'b0;
  logic [AW-1:0] exp_addr = '0, prev_addr = '0;
  bit  go_req = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [LW-1:0] req_len = '0;
  int  ack_mode = 0, wait_mode = 0, lat_max = 1;

  function automatic logic [DW-1:0] memval(input logic [AW-1:0] a);
    return a[16:1] ^ 16'hC35A ^ {a[4:1], a[16:5]};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic step();
    bit acc;
    @(negedge clk);
    cyc++;
    if (cyc > WD) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, WD);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
    // compare outputs against the model
    chk(ctl_done == done_m, "R2 R8 done flag", ctl_done, done_m);
    chk(usr_avail == (mq.size() != 0), "R6 avail", usr_avail, mq.size() != 0);
    if (mq.size() != 0) chk(usr_data == mq[0], "R6 head word", usr_data, mq[0]);
    if (bus_read) begin
      if (prev_hold) chk(bus_addr == prev_addr, "R4 address held", bus_addr, prev_addr);
      else chk(mq.size() + infl < LIMIT, "R5 throttle", mq.size() + infl, LIMIT);
      chk(issued < total && !done_m, "R3 no extra request", issued, total);
    end else if (prev_hold) chk(1'b0, "R4 read held", 0, 1);
    // drive inputs
    ctl_go = go_req;
    ctl_addr = req_addr;
    ctl_len = req_len;
    go_req = 1'b0;
    bus_waitreq = (wait_mode != 0) ? ($urandom % 3 == 0) : 1'b0;
    bus_rvalid = 1'b0;
    if (resp_t.size() != 0 && resp_t[0] <= cyc) begin
      bus_rvalid = 1'b1;
      bus_rdata = resp_d.pop_front();
      void'(resp_t.pop_front());
    end
    usr_ack = (ack_mode == 0) ? 1'b1 : (ack_mode == 1) ? 1'($urandom % 2) : 1'b0;
    // model of the coming clock edge
    acc = bus_read && !bus_waitreq;
    if (acc) begin
      int due;
      chk(bus_addr == exp_addr, "R3 address", bus_addr, exp_addr);
      due = cyc + 1 + int'($urandom % lat_max);
      if (due < last_due) due = last_due;
      last_due = due;
      resp_t.push_back(due);
      resp_d.push_back(memval(bus_addr));
      exp_addr += BE; issued++; infl++;
    end
    if (usr_ack && mq.size() != 0) void'(mq.pop_front());
    if (bus_rvalid) begin
      mq.push_back(bus_rdata);
      infl--; ret++;
      if (ret == total) done_m = 1'b1;
    end
    if (ctl_go && done_m && ctl_len != 0) begin
      done_m = 1'b0; total = (ctl_len + BE - 1) / BE;
      issued = 0; ret = 0; exp_addr = ctl_addr;
    end
    prev_hold = bus_read && bus_waitreq;
    prev_addr = bus_addr;
  endtask

  task automatic start(input logic [AW-1:0] a, input logic [LW-1:0] l);
    req_addr = a; req_len = l; go_req = 1'b1;
    step();
  endtask

  task automatic finish_run();
    while (!(done_m && mq.size() == 0 && resp_t.size() == 0)) step();
    step();
    chk(issued == total, "R3 request count", issued, total);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(ctl_done == 1'b1, "R1 done after reset", ctl_done, 1);
    chk(bus_read == 1'b0, "R1 read after reset", bus_read, 0);
    chk(usr_avail == 1'b0, "R1 avail after reset", usr_avail, 0);

    // R10 zero-length transfer
    start(32'h100, 16'd0);
    repeat (6) begin
      step();
      chk(!bus_read && ctl_done, "R10 zero length idle", {bus_read, ctl_done}, 2'b01);
    end

    // fast slave, consumer always acks (covers R7 ack while empty)
    ack_mode = 0; wait_mode = 0; lat_max = 1;
    start(32'h1000, 16'd16);
    finish_run();
    repeat (4) step();
    chk(!usr_avail, "R7 empty ack no effect", usr_avail, 0);

    // random stalls and latency, random consumer
    ack_mode = 1; wait_mode = 1; lat_max = 6;
    start(32'h2000, 16'd80);
    finish_run();

    // odd byte length rounds up (R2)
    start(32'h3000, 16'd5);
    finish_run();
    chk(total == 3, "R2 word count", total, 3);

    // R9 restart strobe while busy ignored
    ack_mode = 0; wait_mode = 1; lat_max = 3;
    start(32'h4000, 16'd40);
    repeat (3) step();
    start(32'h9000, 16'd2);
    finish_run();
    chk(total == 20 && exp_addr == 32'h4000 + 40, "R9 busy go ignored", exp_addr, 32'h4000 + 40);

    // R5 stalled consumer: buffer settles at the limit
    ack_mode = 2; wait_mode = 0; lat_max = 4;
    start(32'h5000, 16'd120);
    repeat (200) step();
    chk(mq.size() == LIMIT, "R5 stall level", mq.size(), LIMIT);
    chk(!bus_read, "R5 no request when full", bus_read, 0);
    chk(!ctl_done, "R8 not done while words remain", ctl_done, 0);
    ack_mode = 1;
    finish_run();

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule